// File: doc/BRIEF.md
# 16-bit Dual-Trigger Capture Timer

This block is a 16-bit free-running up-counter with two capture registers. Each capture register latches the counter when a trigger strobe arrives. The counter normally advances on an internal count clock that is derived from the system clock by a selectable prescaler. It can instead advance on each valid edge of trigger input A. Both trigger inputs arrive as one-cycle strobes that an upstream noise filter has already produced: a valid edge of A, the opposite edge of A, and a valid edge of B.

Each count-clock period has a rising phase and a falling phase. Each phase is a one-system-clock enable, and the falling phase comes half a period after the rising one.
- A trigger is held pending until the next falling phase.
- At that falling phase the counter value is latched.
- The interrupt for that capture is raised only at the following rising phase.

A source select for capture register 0 picks one of two modes:
- In the first mode, register 0 captures on edges of input B.
- In the second mode, register 0 captures on the opposite edge of A and raises no interrupt. An edge on B then gives only an interrupt, with no capture.

Capture register 1 always follows the valid edge of A. When the timer is stopped, the counter and the phase generator are cleared, and all triggers are ignored.

Top module: `cap_timer16`

## Requirements
- R1: After reset both capture outputs read 0 and both interrupt outputs are low.
- R2: With internal counting, the counter advances by one once per count-clock period. The period is 2, 8, 32 or 128 system clocks for `div_sel` values 0, 1, 2 and 3. The counter wraps from 0xFFFF to 0x0000.
- R3: A trigger strobe is held until the next falling phase. The falling phase is half a period after the rising phase, and a period starts on the first running cycle. At that falling phase the current counter value is loaded: into `cap1` for a valid edge of A, and into `cap0` for an edge of B when `cap0_src` is 0.
- R4: A capture that raises an interrupt gives a one-cycle high pulse on its interrupt output. The pulse comes in the system cycle after the next rising phase.
- R5: With `cap0_src` = 1, `cap0` loads on the opposite edge of A, and no pulse appears on `irq0` for that capture.
- R6: With `cap0_src` = 1, an edge of B leaves `cap0` unchanged. It still gives an `irq0` pulse, with the same timing as R4.
- R7: With `ext_count` = 1, the counter advances once per valid-edge strobe of A and wraps as in R2. No capture is triggered by either edge of A, and B captures keep working.
- R8: While `run` is low, the counter and the count-clock phase are cleared, triggers are ignored, the capture outputs hold and the interrupts stay low. After `run` rises, counting restarts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Timer enable; low stops and clears the timer |
| div_sel | input | 2 | Count-clock prescaler select (half period 1, 4, 16, 64) |
| ext_count | input | 1 | 1: count on valid edges of A instead of the prescaler |
| cap0_src | input | 1 | 0: cap0 from B; 1: cap0 from opposite edge of A |
| trig_a | input | 1 | Filtered valid-edge strobe of input A |
| trig_a_opp | input | 1 | Filtered opposite-edge strobe of input A |
| trig_b | input | 1 | Filtered valid-edge strobe of input B |
| cap0 | output | 16 | Capture register 0 |
| cap1 | output | 16 | Capture register 1 |
| irq0 | output | 1 | Interrupt pulse for channel 0 |
| irq1 | output | 1 | Interrupt pulse for channel 1 |

## Verification
A wrong count-clock phase shows up within one period: every capture lands on a shifted counter value, and the interrupt pulses move by whole system cycles. A wrong counter value first appears in the next capture. A lost or stuck pending trigger shows up as a missing or repeated capture at the next falling phase. A stale interrupt arm shows up as a stray pulse at the next rising phase. The bench's reference model compares all four outputs on every cycle, so each of these faults is flagged within one count-clock period of the triggering stimulus.

// File: rtl/cap_timer16_pkg.sv
package cap_timer16_pkg;
  localparam int CT_CNT_W    = 16;
  localparam int CT_SEL_W    = 2;
  localparam int CT_DIV_STEP = 2;

  typedef enum logic {
    CAP0_FROM_B     = 1'b0,
    CAP0_FROM_A_OPP = 1'b1
  } cap0_src_e;
endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
  parameter int SEL_W    = 2,
  parameter int DIV_STEP = 2,
  parameter int PC_W     = ((1 << SEL_W) - 1) * DIV_STEP + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             rise_en,
  output logic             fall_en
);
  logic [PC_W-1:0] pc_q, pc_d;
  logic [PC_W-1:0] half;
  logic [PC_W-1:0] last;

  always_comb begin
    half = {{(PC_W-1){1'b0}}, 1'b1} << (DIV_STEP * int'(sel));
    last = half | (half - 1'b1);
    if (!run) begin
      pc_d = '0;
    end else if (pc_q >= last) begin
      pc_d = '0;
    end else begin
      pc_d = pc_q + 1'b1;
    end
    rise_en = run && (pc_q == '0);
    fall_en = run && (pc_q == half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // R3
  fall_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'd0 && $past(sel) == 2'd0 && fall_en && $past(run)) |-> $past(rise_en));
endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ext_mode,
  input  logic             rise_en,
  input  logic             a_edge,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  always_comb begin
    step = ext_mode ? a_edge : rise_en;
    if (!run)      cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ext_mode && rise_en && cnt_q == {CNT_W{1'b1}}) |=> cnt_q == '0);

  // R8
  stopped_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/ct_capture_ch.sv
module ct_capture_ch #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             rise_en,
  input  logic             fall_en,
  input  logic             cap_trig,
  input  logic             irq_trig,
  input  logic             cap_irq_en,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap,
  output logic             irq
);
  logic             pend_cap_q, pend_cap_d;
  logic             pend_irq_q, pend_irq_d;
  logic             arm_q, arm_d;
  logic [CNT_W-1:0] cap_q, cap_d;
  logic             irq_q, irq_d;
  logic             take_cap, take_irq;

  always_comb begin
    take_cap = run && fall_en && (pend_cap_q || cap_trig);
    take_irq = run && fall_en && (pend_irq_q || irq_trig);

    if (!run) begin
      pend_cap_d = 1'b0;
      pend_irq_d = 1'b0;
      arm_d      = 1'b0;
    end else begin
      pend_cap_d = take_cap ? 1'b0 : (pend_cap_q || cap_trig);
      pend_irq_d = take_irq ? 1'b0 : (pend_irq_q || irq_trig);
      arm_d      = (rise_en ? 1'b0 : arm_q) || (take_cap && cap_irq_en) || take_irq;
    end

    cap_d = take_cap ? cnt : cap_q;
    irq_d = run && rise_en && arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cap_q <= 1'b0;
      pend_irq_q <= 1'b0;
      arm_q      <= 1'b0;
      cap_q      <= '0;
      irq_q      <= 1'b0;
    end else begin
      pend_cap_q <= pend_cap_d;
      pend_irq_q <= pend_irq_d;
      arm_q      <= arm_d;
      cap_q      <= cap_d;
      irq_q      <= irq_d;
    end
  end

  assign cap = cap_q;
  assign irq = irq_q;

  // R4
  irq_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(rise_en));

  // R4
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R3
  cap_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_q) |-> $past(fall_en));
endmodule

// File: rtl/cap_timer16.sv
module cap_timer16
  import cap_timer16_pkg::*;
#(
  parameter int CNT_W    = CT_CNT_W,
  parameter int SEL_W    = CT_SEL_W,
  parameter int DIV_STEP = CT_DIV_STEP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             ext_count,
  input  logic             cap0_src,
  input  logic             trig_a,
  input  logic             trig_a_opp,
  input  logic             trig_b,
  output logic [CNT_W-1:0] cap0,
  output logic [CNT_W-1:0] cap1,
  output logic             irq0,
  output logic             irq1
);
  localparam int PC_W  = ((1 << SEL_W) - 1) * DIV_STEP + 1;
  localparam int N_CH  = 2;

  logic             rise_en, fall_en;
  logic [CNT_W-1:0] cnt;
  logic             a_cap_ok;
  logic [N_CH-1:0]  ch_cap_trig, ch_irq_trig, ch_irq_en, ch_irq;
  logic [CNT_W-1:0] ch_cap [N_CH];
  cap0_src_e        src0;

  always_comb begin
    src0     = cap0_src_e'(cap0_src);
    a_cap_ok = !ext_count;
    if (src0 == CAP0_FROM_A_OPP) begin
      ch_cap_trig[0] = trig_a_opp && a_cap_ok;
      ch_irq_trig[0] = trig_b;
      ch_irq_en[0]   = 1'b0;
    end else begin
      ch_cap_trig[0] = trig_b;
      ch_irq_trig[0] = 1'b0;
      ch_irq_en[0]   = 1'b1;
    end
    ch_cap_trig[1] = trig_a && a_cap_ok;
    ch_irq_trig[1] = 1'b0;
    ch_irq_en[1]   = 1'b1;
  end

  ct_prescaler #(.SEL_W(SEL_W), .DIV_STEP(DIV_STEP), .PC_W(PC_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .sel     (div_sel),
    .rise_en (rise_en),
    .fall_en (fall_en)
  );

  ct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .ext_mode (ext_count),
    .rise_en  (rise_en),
    .a_edge   (trig_a),
    .cnt      (cnt)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    ct_capture_ch #(.CNT_W(CNT_W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .rise_en    (rise_en),
      .fall_en    (fall_en),
      .cap_trig   (ch_cap_trig[g]),
      .irq_trig   (ch_irq_trig[g]),
      .cap_irq_en (ch_irq_en[g]),
      .cnt        (cnt),
      .cap        (ch_cap[g]),
      .irq        (ch_irq[g])
    );
  end

  assign cap0 = ch_cap[0];
  assign cap1 = ch_cap[1];
  assign irq0 = ch_irq[0];
  assign irq1 = ch_irq[1];

  // R8
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(cap0) && $stable(cap1)));

  // R8
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!irq0 && !irq1));
endmodule

// File: tb/cap_timer16_tb.sv
module cap_timer16_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [1:0]  div_sel = 2'd0;
  logic        ext_count = 1'b0;
  logic        cap0_src = 1'b0;
  logic        trig_a = 1'b0;
  logic        trig_a_opp = 1'b0;
  logic        trig_b = 1'b0;
  logic [15:0] cap0, cap1;
  logic        irq0, irq1;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  cap_timer16 u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .div_sel(div_sel),
    .ext_count(ext_count), .cap0_src(cap0_src), .trig_a(trig_a),
    .trig_a_opp(trig_a_opp), .trig_b(trig_b),
    .cap0(cap0), .cap1(cap1), .irq0(irq0), .irq1(irq1)
  );

  // behavioural reference
  int          m_t;
  int unsigned m_cnt, m_cap0, m_cap1;
  bit          m_p0, m_p1, m_pi0, m_arm0, m_arm1, m_irq0, m_irq1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_t = 0; m_cnt = 0; m_cap0 = 0; m_cap1 = 0;
      m_p0 = 0; m_p1 = 0; m_pi0 = 0; m_arm0 = 0; m_arm1 = 0;
      m_irq0 = 0; m_irq1 = 0;
    end else if (!run) begin
      m_t = 0; m_cnt = 0;
      m_p0 = 0; m_p1 = 0; m_pi0 = 0; m_arm0 = 0; m_arm1 = 0;
      m_irq0 = 0; m_irq1 = 0;
    end else begin
      int  h, per, ph;
      bit  rise, fall, step;
      h    = 1 << (2 * int'(div_sel));
      per  = 2 * h;
      ph   = m_t % per;
      rise = (ph == 0);
      fall = (ph == h);
      m_irq0 = rise && m_arm0;
      m_irq1 = rise && m_arm1;
      if (rise) begin m_arm0 = 0; m_arm1 = 0; end
      if (cap0_src) begin
        if (trig_a_opp && !ext_count) m_p0 = 1;
        if (trig_b) m_pi0 = 1;
      end else if (trig_b) m_p0 = 1;
      if (trig_a && !ext_count) m_p1 = 1;
      if (fall) begin
        if (m_p0) begin m_cap0 = m_cnt; if (!cap0_src) m_arm0 = 1; m_p0 = 0; end
        if (m_pi0) begin m_arm0 = 1; m_pi0 = 0; end
        if (m_p1) begin m_cap1 = m_cnt; m_arm1 = 1; m_p1 = 0; end
      end
      step = ext_count ? trig_a : rise;
      if (step) m_cnt = (m_cnt + 1) % 65536;
      m_t++;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "cap0", int'(cap0), int'(m_cap0));
      check(cur_req, "cap1", int'(cap1), int'(m_cap1));
      check(cur_req, "irq0", int'(irq0), int'(m_irq0));
      check(cur_req, "irq1", int'(irq1), int'(m_irq1));
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: trig_a = 1'b1;
      1: trig_a_opp = 1'b1;
      default: trig_b = 1'b1;
    endcase
    @(negedge clk);
    trig_a = 1'b0; trig_a_opp = 1'b0; trig_b = 1'b0;
  endtask

  task automatic stop_run();
    @(negedge clk); run = 1'b0;
    wait_cyc(3);
  endtask

  task automatic start_run(input logic [1:0] s, input logic e, input logic src);
    @(negedge clk);
    div_sel = s; ext_count = e; cap0_src = src; run = 1'b1;
  endtask

  function automatic void summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endfunction

  initial begin
    repeat (195000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    wait_cyc(3);
    // R1 reset state
    check("R1", "cap0 reset", int'(cap0), 0);
    check("R1", "cap1 reset", int'(cap1), 0);
    check("R1", "irq0 reset", int'(irq0), 0);
    check("R1", "irq1 reset", int'(irq1), 0);
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(2);

    // R3 R4 R2: every prescaler setting, B and A captures
    for (int s = 0; s < 4; s++) begin
      cur_req = "R2/R3/R4";
      start_run(2'(s), 1'b0, 1'b0);
      for (int k = 0; k < 6; k++) begin
        wait_cyc(3 + 7 * k + s * 11);
        pulse(2);
        wait_cyc(k);
        pulse(0);
      end
      wait_cyc(300);
      stop_run();
    end

    // R3 directed: first falling phase after start with div 2 captures 1
    cur_req = "R3";
    start_run(2'd0, 1'b0, 1'b0);
    trig_b = 1'b1;
    @(negedge clk); trig_b = 1'b0;
    wait_cyc(4);
    check("R3", "cap0 first fall", int'(cap0), 1);
    stop_run();

    // R5 R6: opposite-phase mode
    cur_req = "R5/R6";
    start_run(2'd1, 1'b0, 1'b1);
    begin
      int irq0_seen = 0;
      int unsigned c0_before;
      for (int k = 0; k < 5; k++) begin
        pulse(1);
        for (int j = 0; j < 20; j++) begin
          @(negedge clk);
          if (irq0) irq0_seen++;
        end
      end
      check("R5", "irq0 after opposite-edge captures", irq0_seen, 0);
      c0_before = cap0;
      irq0_seen = 0;
      pulse(2);
      for (int j = 0; j < 20; j++) begin
        @(negedge clk);
        if (irq0) irq0_seen++;
      end
      check("R6", "cap0 unchanged by B", int'(cap0), int'(c0_before));
      check("R6", "irq0 pulses from B", irq0_seen, 1);
    end
    stop_run();

    // R7 R2: external counting through a wrap, A captures blocked
    cur_req = "R7/R2";
    start_run(2'd0, 1'b1, 1'b0);
    trig_a = 1'b1;
    wait_cyc(65536 + 40);
    trig_a = 1'b0;
    pulse(2);
    pulse(1);
    wait_cyc(10);
    check("R7", "cap0 after wrap small", int'(cap0 < 16'd100), 1);
    check("R7", "cap1 untouched by A", int'(cap1), int'(m_cap1));
    stop_run();
    start_run(2'd2, 1'b1, 1'b1);
    for (int k = 0; k < 5; k++) begin pulse(0); pulse(1); pulse(2); wait_cyc(40); end
    wait_cyc(80);
    stop_run();

    // R8: stopped timer ignores triggers, then restarts from zero
    cur_req = "R8";
    begin
      int unsigned h0, h1;
      int irq_seen = 0;
      h0 = cap0; h1 = cap1;
      for (int k = 0; k < 10; k++) begin
        trig_a = 1'b1; trig_b = 1'b1; trig_a_opp = 1'b1;
        @(negedge clk);
        if (irq0 || irq1) irq_seen++;
      end
      trig_a = 1'b0; trig_b = 1'b0; trig_a_opp = 1'b0;
      wait_cyc(5);
      check("R8", "cap0 hold while stopped", int'(cap0), int'(h0));
      check("R8", "cap1 hold while stopped", int'(cap1), int'(h1));
      check("R8", "irq while stopped", irq_seen, 0);
      start_run(2'd0, 1'b0, 1'b0);
      trig_a = 1'b1;
      @(negedge clk); trig_a = 1'b0;
      wait_cyc(4);
      check("R8", "cap1 after restart", int'(cap1), 1);
    end
    wait_cyc(20);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule